// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block stands between the interrupt sources of a chip and a single CPU core. It records three kinds of request: a reset request, a non-maskable request and a maskable request that carries a level value. It then hands them to the core one at a time, at instruction boundaries marked by an instruction-cycle strobe. Reset and non-maskable requests are sticky until served, and they share one combined exception request output.

A maskable request updates the hardware-interrupt pending field of the core's cause register. That field is a 6-bit register held here and exposed as an output. The request becomes an interrupt exception only when the core's global enable bit is set and the pending level bits overlap the core's interrupt mask. A request that is disabled or masked stays pending and is tried again at every following strobe, until it is accepted or replaced. A level of zero is an end-of-interrupt request: it clears the pending field and raises nothing.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all pending requests are dropped. After that edge `exc_nmirst`, `exc_int` and `cause_ip` are all zero.
- R2: A pending reset request is served at the next sampled `instr_strobe`. Serving it means one cycle of `exc_nmirst` high in the cycle after that edge. No other request is served at that strobe.
- R3: A pending non-maskable request is served like R2, but only at a strobe where no reset request is pending. A pending level or end-of-interrupt request waits until both reset and non-maskable requests are gone.
- R4: Serving a nonzero level request loads `cause_ip` with the low `IP_W` bits of the level, bits [5:0] by default. Bits above these are discarded.
- R5: Serving a nonzero level raises `exc_int` for one cycle only when `sr_ie` is 1 and the low level bits AND `sr_mask` is nonzero. The request is then no longer pending.
- R6: A nonzero level that is disabled or masked when served stays pending. It is served again at every following strobe and updates `cause_ip` each time, until it fires or is replaced.
- R7: A level write of value zero is an end-of-interrupt request. Serving it clears `cause_ip` and raises no exception. It is served once and then is no longer pending.
- R8: A new level write replaces any pending level or end-of-interrupt request.
- R9: Without a sampled `instr_strobe`, no request is served. `exc_nmirst` and `exc_int` stay low in the following cycle, and `cause_ip` does not change.
- R10: A request written at the same edge as a strobe is not seen by that strobe. It is served from the next strobe on. If that strobe serves an older request of the same kind, the new request still stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | One-cycle reset request event |
| req_nmi | input | 1 | One-cycle non-maskable request event |
| lvl_valid | input | 1 | One-cycle level write event |
| lvl_value | input | LVL_W | Level value written with `lvl_valid`; zero means end of interrupt |
| instr_strobe | input | 1 | Instruction boundary: one delivery opportunity |
| sr_ie | input | 1 | Status-register global interrupt enable |
| sr_mask | input | IP_W | Status-register interrupt mask field |
| exc_nmirst | output | 1 | Combined reset/non-maskable exception request pulse |
| exc_int | output | 1 | Maskable interrupt exception request pulse |
| cause_ip | output | IP_W | Cause-register hardware-interrupt pending field |

## Verification
The bench builds the block with its defaults: a 6-bit pending field and an 8-bit level input. The two extra level bits make it possible to show that only the low six bits reach the pending field and the mask test. Requests that have nonzero upper bits but zero low bits remain pending without ever firing, and the bench covers that case too.

Directed phases cover stacked reset and non-maskable requests ahead of a level, masked retries and end-of-interrupt. They also cover level overwrite and requests that arrive at the same edge as a strobe. A long random stretch then mixes events and strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_IP_W  = 6;
    localparam int IRQ_LVL_W = 8;

    typedef enum logic [1:0] {
        LK_NONE,
        LK_EOI,
        LK_ACTIVE
    } lvl_kind_e;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_RESET,
        SEL_NMI,
        SEL_EOI,
        SEL_LEVEL
    } sel_e;

    typedef struct packed {
        logic      rst;
        logic      nmi;
        lvl_kind_e kind;
    } pend_flags_t;

    typedef struct packed {
        sel_e sel;
        logic fire;
    } decision_t;

    function automatic lvl_kind_e classify_level(input logic is_zero);
        return is_zero ? LK_EOI : LK_ACTIVE;
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_pkg::*;
#(
    parameter int LVL_W = IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_reset,
    input  logic             req_nmi,
    input  logic             lvl_valid,
    input  logic [LVL_W-1:0] lvl_value,
    input  logic             clr_rst,
    input  logic             clr_nmi,
    input  logic             clr_lvl,
    output pend_flags_t      flags,
    output logic [LVL_W-1:0] lvl_q
);

    pend_flags_t      flags_n;
    logic [LVL_W-1:0] lvl_n;

    always_comb begin
        flags_n = flags;
        lvl_n   = lvl_q;
        // service clears first, fresh events override them
        if (clr_rst) flags_n.rst = 1'b0;
        if (clr_nmi) flags_n.nmi = 1'b0;
        if (clr_lvl) flags_n.kind = LK_NONE;
        if (req_reset) flags_n.rst = 1'b1;
        if (req_nmi)   flags_n.nmi = 1'b1;
        if (lvl_valid) begin
            flags_n.kind = classify_level(lvl_value == '0);
            lvl_n        = lvl_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '{rst: 1'b0, nmi: 1'b0, kind: LK_NONE};
            lvl_q <= '0;
        end else begin
            flags <= flags_n;
            lvl_q <= lvl_n;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int IP_W  = IRQ_IP_W,
    parameter int LVL_W = IRQ_LVL_W
) (
    input  pend_flags_t      flags,
    input  logic [LVL_W-1:0] lvl_q,
    input  logic             sr_ie,
    input  logic [IP_W-1:0]  sr_mask,
    output decision_t        dec
);

    logic [IP_W-1:0] low_bits;
    assign low_bits = lvl_q[IP_W-1:0];

    always_comb begin
        dec.sel  = SEL_IDLE;
        dec.fire = 1'b0;
        if (flags.rst) begin
            dec.sel = SEL_RESET;
        end else if (flags.nmi) begin
            dec.sel = SEL_NMI;
        end else if (flags.kind == LK_EOI) begin
            dec.sel = SEL_EOI;
        end else if (flags.kind == LK_ACTIVE) begin
            dec.sel  = SEL_LEVEL;
            dec.fire = sr_ie && ((low_bits & sr_mask) != '0);
        end
    end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
    import irq_pkg::*;
#(
    parameter int IP_W  = IRQ_IP_W,
    parameter int LVL_W = IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  decision_t        dec,
    input  logic [LVL_W-1:0] lvl_q,
    output logic [IP_W-1:0]  cause_ip,
    output logic             exc_nmirst,
    output logic             exc_int
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_ip   <= '0;
            exc_nmirst <= 1'b0;
            exc_int    <= 1'b0;
        end else begin
            exc_nmirst <= 1'b0;
            exc_int    <= 1'b0;
            if (strobe) begin
                unique case (dec.sel)
                    SEL_RESET, SEL_NMI: exc_nmirst <= 1'b1;
                    SEL_EOI:            cause_ip   <= '0;
                    SEL_LEVEL: begin
                        cause_ip <= lvl_q[IP_W-1:0];
                        exc_int  <= dec.fire;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl
    import irq_pkg::*;
#(
    parameter int IP_W  = IRQ_IP_W,
    parameter int LVL_W = IRQ_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_reset,
    input  logic             req_nmi,
    input  logic             lvl_valid,
    input  logic [LVL_W-1:0] lvl_value,
    input  logic             instr_strobe,
    input  logic             sr_ie,
    input  logic [IP_W-1:0]  sr_mask,
    output logic             exc_nmirst,
    output logic             exc_int,
    output logic [IP_W-1:0]  cause_ip
);

    pend_flags_t      flags;
    logic [LVL_W-1:0] lvl_q;
    decision_t        dec;
    logic             clr_rst, clr_nmi, clr_lvl;

    assign clr_rst = instr_strobe && (dec.sel == SEL_RESET);
    assign clr_nmi = instr_strobe && (dec.sel == SEL_NMI);
    assign clr_lvl = instr_strobe &&
                     ((dec.sel == SEL_EOI) || (dec.sel == SEL_LEVEL && dec.fire));

    irq_req_latch #(.LVL_W(LVL_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .req_reset (req_reset),
        .req_nmi   (req_nmi),
        .lvl_valid (lvl_valid),
        .lvl_value (lvl_value),
        .clr_rst   (clr_rst),
        .clr_nmi   (clr_nmi),
        .clr_lvl   (clr_lvl),
        .flags     (flags),
        .lvl_q     (lvl_q)
    );

    irq_arbiter #(.IP_W(IP_W), .LVL_W(LVL_W)) u_arb (
        .flags   (flags),
        .lvl_q   (lvl_q),
        .sr_ie   (sr_ie),
        .sr_mask (sr_mask),
        .dec     (dec)
    );

    irq_cause_reg #(.IP_W(IP_W), .LVL_W(LVL_W)) u_cause (
        .clk        (clk),
        .rst        (rst),
        .strobe     (instr_strobe),
        .dec        (dec),
        .lvl_q      (lvl_q),
        .cause_ip   (cause_ip),
        .exc_nmirst (exc_nmirst),
        .exc_int    (exc_int)
    );

endmodule

// File: rtl/irq_delivery_chk.sv
module irq_delivery_chk #(
    parameter int IP_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            instr_strobe,
    input logic            sr_ie,
    input logic [IP_W-1:0] sr_mask,
    input logic            exc_nmirst,
    input logic            exc_int,
    input logic [IP_W-1:0] cause_ip
);

    AST_NMIRST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (exc_nmirst && !$past(rst)) |-> $past(instr_strobe)); // R9

    AST_INT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (exc_int && !$past(rst)) |-> $past(instr_strobe)); // R9

    AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(exc_nmirst && exc_int)); // R2

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(instr_strobe)) |-> $stable(cause_ip)); // R9

    AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (exc_int && !$past(rst)) |-> $past(sr_ie)); // R5

    AST_INT_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (exc_int && !$past(rst)) |-> (($past(sr_mask) & cause_ip) != '0)); // R5

endmodule

bind irq_delivery_ctrl irq_delivery_chk #(.IP_W(IP_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .instr_strobe (instr_strobe),
    .sr_ie        (sr_ie),
    .sr_mask      (sr_mask),
    .exc_nmirst   (exc_nmirst),
    .exc_int      (exc_int),
    .cause_ip     (cause_ip)
);

// File: tb/tb_irq_delivery_ctrl.sv
module tb_irq_delivery_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int IP_W  = 6;
    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_reset = 1'b0;
    logic             req_nmi = 1'b0;
    logic             lvl_valid = 1'b0;
    logic [LVL_W-1:0] lvl_value = '0;
    logic             instr_strobe = 1'b0;
    logic             sr_ie = 1'b0;
    logic [IP_W-1:0]  sr_mask = '0;
    logic             exc_nmirst, exc_int;
    logic [IP_W-1:0]  cause_ip;

    irq_delivery_ctrl #(.IP_W(IP_W), .LVL_W(LVL_W)) dut (
        .clk(clk), .rst(rst), .req_reset(req_reset), .req_nmi(req_nmi),
        .lvl_valid(lvl_valid), .lvl_value(lvl_value), .instr_strobe(instr_strobe),
        .sr_ie(sr_ie), .sr_mask(sr_mask), .exc_nmirst(exc_nmirst),
        .exc_int(exc_int), .cause_ip(cause_ip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int    m_prst = 0, m_pnmi = 0, m_kind = 0, m_lvl = 0;
    int    m_cause = 0, m_xr = 0, m_xi = 0;
    int    vectors = 0, miscompares = 0, cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always @(posedge clk) begin
        int nr, ni;
        nr = 0; ni = 0;
        if (rst) begin
            m_prst = 0; m_pnmi = 0; m_kind = 0; m_lvl = 0; m_cause = 0;
        end else begin
            if (instr_strobe) begin
                if (m_prst != 0) begin m_prst = 0; nr = 1; end
                else if (m_pnmi != 0) begin m_pnmi = 0; nr = 1; end
                else if (m_kind == 1) begin m_cause = 0; m_kind = 0; end
                else if (m_kind == 2) begin
                    m_cause = m_lvl % 64;
                    if (sr_ie && ((m_lvl % 64) & int'(sr_mask)) != 0) begin
                        ni = 1; m_kind = 0;
                    end
                end
            end
            if (req_reset) m_prst = 1;
            if (req_nmi)   m_pnmi = 1;
            if (lvl_valid) begin
                m_lvl  = int'(lvl_value);
                m_kind = (lvl_value == '0) ? 1 : 2;
            end
        end
        m_xr = nr; m_xi = ni;
        cycles++;
    end

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (int'(exc_nmirst) != m_xr || int'(exc_int) != m_xi ||
                int'(cause_ip) != m_cause) begin
                miscompares++;
                $display("FAIL %s t=%0t: nmirst=%0d int=%0d cause=%0d, expected %0d %0d %0d",
                         cur_req, $time, exc_nmirst, exc_int, cause_ip, m_xr, m_xi, m_cause);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input bit r, input bit n, input bit lv, input int val, input bit stb);
        req_reset = r; req_nmi = n; lvl_valid = lv;
        lvl_value = LVL_W'(val); instr_strobe = stb;
        tick(1);
        req_reset = 0; req_nmi = 0; lvl_valid = 0; instr_strobe = 0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        tick(1);
        cur_req = "R1"; rst = 1; tick(3); rst = 0; tick(2);
        cur_req = "R2"; drive(1, 0, 0, 0, 0); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R3"; sr_ie = 1; sr_mask = 6'h3F;
        drive(1, 1, 1, 5, 0);
        drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R4"; sr_ie = 0; drive(0, 0, 1, 'hC5, 0); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R5"; sr_ie = 1; sr_mask = 6'h01; drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R6"; sr_mask = 6'h01; drive(0, 0, 1, 'h20, 0);
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1);
        sr_ie = 0; sr_mask = 6'h20; drive(0, 0, 0, 0, 1);
        sr_ie = 1; drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1);
        drive(0, 0, 1, 'h40, 0); drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R7"; drive(0, 0, 1, 0, 0); drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1);
        sr_ie = 0; drive(0, 0, 1, 9, 1); drive(0, 0, 0, 0, 1); drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R8"; sr_ie = 1; sr_mask = 6'h04;
        drive(0, 0, 1, 3, 0); drive(0, 0, 1, 12, 0); drive(0, 0, 0, 0, 1);
        drive(0, 0, 1, 7, 0); drive(0, 0, 1, 0, 0); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R9"; drive(1, 1, 1, 6, 0); tick(5);
        drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R10"; sr_mask = 6'h3F;
        drive(1, 0, 0, 0, 0); drive(1, 0, 0, 0, 1); drive(0, 0, 0, 0, 1);
        drive(0, 0, 1, 2, 0); drive(0, 0, 1, 1, 1); drive(0, 0, 0, 0, 1); tick(2);
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            sr_ie   = ($urandom % 4) != 0;
            sr_mask = IP_W'($urandom);
            drive(($urandom % 23) == 0, ($urandom % 19) == 0, ($urandom % 6) == 0,
                  (($urandom % 5) == 0) ? 0 : int'($urandom % 256), ($urandom % 3) != 0);
        end
        cur_req = "R1"; drive(1, 1, 1, 4, 0); rst = 1; tick(2); rst = 0; tick(3);
        finish_run();
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: cycles=%0d, expected completion", cycles);
            finish_run();
        end
    end

endmodule